// File: doc/BRIEF.md
# Indirect Call Type Guard

This block checks the forward edges of a monitored program's control flow. Instrumented code sends one message before each indirect call. The message names the call site and gives the address the call will jump to. The guard looks up the type class that the call site expects. It then finds the function that sits at the target address and compares that function's type class with the expected one. The call is accepted only when a known function sits at that address and the two classes are the same. In every other case the call is a violation.

Loading happens through a configuration port while the platform boots. The port writes the call-site table, the function table and a code base address. Function entries hold offsets from the start of the code image. The absolute address of a function is the base plus its offset, so the function table follows wherever the image is relocated. Once the lock input is raised, configuration is frozen. Each checked message produces a single-cycle verdict. A failing verdict also sets a sticky violation flag that a remediation agent can watch.

The controller has three states. ST_SITE waits for the first packet of a message. A valid packet moves it to ST_TARGET, which waits for the second packet. The second packet moves it to ST_CHECK. There the verdict is formed. From ST_CHECK the controller returns to ST_SITE, or goes straight to ST_TARGET when a new first packet arrives in that cycle.

Top module: `icall_type_guard`

## Requirements
- R1: After reset `res_valid_o`, `res_pass_o`, `violation_o` and `cfg_err_o` are low, and both tables hold no valid entries.
- R2: A message is two packets on `pkt_data_i`, each qualified by `pkt_valid_i`. The first carries the call-site id in bits [SITE_W-1:0]; the second is the full branch-target address. `res_valid_o` is high for exactly one cycle, starting at the second clock edge after the edge that accepts the target packet. `res_site_o` then gives the site id of that message, and `res_pass_o` is only ever high together with `res_valid_o`.
- R3: Configuration writes use `cfg_sel_i`. Code 2'b00 sets the base from `cfg_addr_i`. Code 2'b01 writes call-site entry `cfg_idx_i` with type `cfg_type_i`. Code 2'b10 writes function entry `cfg_idx_i` with offset `cfg_addr_i` and type `cfg_type_i`. Code 2'b11 changes nothing. A call passes when its site was loaded, its target equals base plus the offset of a loaded function, and the two types are equal.
- R4: A call whose target matches a function with a different type than the site expects fails, and `res_site_o` reports the site id.
- R5: A call whose target matches no loaded function (base plus offset) fails.
- R6: A call from a site id that was never loaded fails.
- R7: `violation_o` rises together with the first failing verdict. Passing verdicts do not clear it; only reset does.
- R8: Target lookups always use the most recently written base, so rewriting the base before lock relocates every function entry.
- R9: Once `lock_i` has been high, the lock persists until reset. Any configuration write made while the lock is active leaves the tables and the base unchanged and sets the sticky `cfg_err_o`. Writes made before lock never set it.
- R10: The first packet of a new message may arrive in the cycle the previous verdict is formed. No packet is lost, and verdicts appear in message order.
- R11: When several function entries hold the same offset, the entry with the lowest index decides the type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Freezes configuration from the cycle it is seen high |
| cfg_valid_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write kind: base, call-site entry, function entry, none |
| cfg_idx_i | input | SITE_W | Table entry index |
| cfg_addr_i | input | ADDR_W | Base address or function offset |
| cfg_type_i | input | TYPE_W | Type class for a table entry |
| pkt_valid_i | input | 1 | Packet qualifier |
| pkt_data_i | input | ADDR_W | Packet payload: site id, then target address |
| res_valid_o | output | 1 | Verdict strobe |
| res_pass_o | output | 1 | Verdict is a pass |
| res_site_o | output | SITE_W | Call-site id of the verdict |
| violation_o | output | 1 | Sticky: some verdict failed |
| cfg_err_o | output | 1 | Sticky: configuration written while locked |

## Verification
The assertions check the timing rules on every cycle. Each verdict strobe lasts one cycle and follows a target packet two edges earlier. A pass always comes with the strobe. A failing verdict always raises the violation flag. Both sticky flags stay high, and a write under lock always sets the error flag. Whether a given verdict is right depends on the loaded tables, the current base and the lowest-index rule. Only the bench's scenarios show this, by checking each verdict against an independent model. The same scenarios also show that writes under lock have no effect, that relocation works, and that back-to-back messages are handled.

// File: rtl/icg_pkg.sv
package icg_pkg;

    typedef enum logic [1:0] {
        ST_SITE   = 2'd0,
        ST_TARGET = 2'd1,
        ST_CHECK  = 2'd2
    } icg_state_e;

    typedef enum logic [1:0] {
        SEL_BASE = 2'b00,
        SEL_SITE = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_NONE = 2'b11
    } icg_sel_e;

endpackage

// File: rtl/icg_cfg_gate.sv
module icg_cfg_gate
    import icg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              cfg_valid_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    output logic              wr_site_o,
    output logic              wr_func_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              cfg_err_o
);

    logic              locked_q;
    logic              err_q;
    logic [ADDR_W-1:0] base_q;
    logic              frozen;
    logic              accept;
    icg_sel_e          sel;

    assign sel    = icg_sel_e'(cfg_sel_i);
    assign frozen = lock_i | locked_q;
    assign accept = cfg_valid_i & ~frozen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            err_q    <= 1'b0;
            base_q   <= '0;
        end else begin
            locked_q <= frozen;
            if (cfg_valid_i && frozen) begin
                err_q <= 1'b1;
            end
            if (accept && sel == SEL_BASE) begin
                base_q <= cfg_addr_i;
            end
        end
    end

    assign wr_site_o = accept && (sel == SEL_SITE);
    assign wr_func_o = accept && (sel == SEL_FUNC);
    assign base_o    = base_q;
    assign cfg_err_o = err_q;

endmodule

// File: rtl/icg_site_table.sv
module icg_site_table #(
    parameter int SITE_W = 8,
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SITE_W-1:0] wr_idx_i,
    input  logic [TYPE_W-1:0] wr_type_i,
    input  logic [SITE_W-1:0] rd_idx_i,
    output logic [TYPE_W-1:0] rd_type_o,
    output logic              rd_known_o
);

    localparam int SITE_N = 1 << SITE_W;

    logic [TYPE_W-1:0] type_q [SITE_N];
    logic [SITE_N-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            type_q[wr_idx_i] <= wr_type_i;
        end
    end

    assign rd_type_o  = type_q[rd_idx_i];
    assign rd_known_o = vld_q[rd_idx_i];

endmodule

// File: rtl/icg_func_cam.sv
module icg_func_cam #(
    parameter int ADDR_W = 32,
    parameter int FUNC_N = 256,
    parameter int TYPE_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en_i,
    input  logic [((FUNC_N > 1) ? $clog2(FUNC_N) : 1)-1:0] wr_idx_i,
    input  logic [ADDR_W-1:0]                      wr_off_i,
    input  logic [TYPE_W-1:0]                      wr_type_i,
    input  logic [ADDR_W-1:0]                      key_i,
    output logic                                   hit_o,
    output logic [TYPE_W-1:0]                      hit_type_o
);

    logic [ADDR_W-1:0] off_q  [FUNC_N];
    logic [TYPE_W-1:0] type_q [FUNC_N];
    logic [FUNC_N-1:0] vld_q;
    logic [FUNC_N-1:0] match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            off_q[wr_idx_i]  <= wr_off_i;
            type_q[wr_idx_i] <= wr_type_i;
        end
    end

    for (genvar g = 0; g < FUNC_N; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (off_q[g] == key_i);
    end

    // Scan downwards so the lowest matching index is the last one assigned.
    always_comb begin
        hit_o      = 1'b0;
        hit_type_o = '0;
        for (int i = FUNC_N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o      = 1'b1;
                hit_type_o = type_q[i];
            end
        end
    end

endmodule

// File: rtl/icall_type_guard.sv
module icall_type_guard
    import icg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SITE_W = 8,
    parameter int FUNC_N = 256,
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              cfg_valid_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [SITE_W-1:0] cfg_idx_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [TYPE_W-1:0] cfg_type_i,
    input  logic              pkt_valid_i,
    input  logic [ADDR_W-1:0] pkt_data_i,
    output logic              res_valid_o,
    output logic              res_pass_o,
    output logic [SITE_W-1:0] res_site_o,
    output logic              violation_o,
    output logic              cfg_err_o
);

    localparam int FUNC_W = (FUNC_N > 1) ? $clog2(FUNC_N) : 1;

    icg_state_e        state_q, state_d;
    logic [SITE_W-1:0] site_q;
    logic [ADDR_W-1:0] target_q;
    logic              res_valid_q, res_pass_q, viol_q;
    logic [SITE_W-1:0] res_site_q;

    logic              wr_site, wr_func;
    logic [ADDR_W-1:0] base;
    logic [TYPE_W-1:0] site_type, func_type;
    logic              site_known, func_hit;
    logic [ADDR_W-1:0] rel_key;
    logic              verdict;
    logic              take_site;

    icg_cfg_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_i     (lock_i),
        .cfg_valid_i(cfg_valid_i),
        .cfg_sel_i  (cfg_sel_i),
        .cfg_addr_i (cfg_addr_i),
        .wr_site_o  (wr_site),
        .wr_func_o  (wr_func),
        .base_o     (base),
        .cfg_err_o  (cfg_err_o)
    );

    icg_site_table #(.SITE_W(SITE_W), .TYPE_W(TYPE_W)) u_sites (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_site),
        .wr_idx_i  (cfg_idx_i),
        .wr_type_i (cfg_type_i),
        .rd_idx_i  (site_q),
        .rd_type_o (site_type),
        .rd_known_o(site_known)
    );

    assign rel_key = target_q - base;

    icg_func_cam #(.ADDR_W(ADDR_W), .FUNC_N(FUNC_N), .TYPE_W(TYPE_W)) u_funcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_func),
        .wr_idx_i  (cfg_idx_i[FUNC_W-1:0]),
        .wr_off_i  (cfg_addr_i),
        .wr_type_i (cfg_type_i),
        .key_i     (rel_key),
        .hit_o     (func_hit),
        .hit_type_o(func_type)
    );

    assign verdict   = site_known && func_hit && (site_type == func_type);
    assign take_site = pkt_valid_i && (state_q == ST_SITE || state_q == ST_CHECK);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SITE:   if (pkt_valid_i) state_d = ST_TARGET;
            ST_TARGET: if (pkt_valid_i) state_d = ST_CHECK;
            ST_CHECK:  state_d = pkt_valid_i ? ST_TARGET : ST_SITE;
            default:   state_d = ST_SITE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SITE;
        else        state_q <= state_d;
    end

    // Packet capture and verdict outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            site_q      <= '0;
            target_q    <= '0;
            res_valid_q <= 1'b0;
            res_pass_q  <= 1'b0;
            res_site_q  <= '0;
            viol_q      <= 1'b0;
        end else begin
            if (take_site) site_q <= pkt_data_i[SITE_W-1:0];
            if (pkt_valid_i && state_q == ST_TARGET) target_q <= pkt_data_i;
            res_valid_q <= (state_q == ST_CHECK);
            res_pass_q  <= (state_q == ST_CHECK) && verdict;
            if (state_q == ST_CHECK) begin
                res_site_q <= site_q;
                if (!verdict) viol_q <= 1'b1;
            end
        end
    end

    assign res_valid_o = res_valid_q;
    assign res_pass_o  = res_pass_q;
    assign res_site_o  = res_site_q;
    assign violation_o = viol_q;

endmodule

// File: rtl/icg_checker.sv
module icg_checker (
    input logic clk,
    input logic rst_n,
    input logic lock_i,
    input logic cfg_valid_i,
    input logic pkt_valid_i,
    input logic res_valid_o,
    input logic res_pass_o,
    input logic violation_o,
    input logic cfg_err_o
);

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o); // R2

    AST_RESULT_FOLLOWS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(pkt_valid_i, 2)); // R2

    AST_PASS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        res_pass_o |-> res_valid_o); // R2

    AST_FAIL_RAISES_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_pass_o) |-> violation_o); // R7

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        violation_o |=> violation_o); // R7

    AST_CFG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o); // R9

    AST_LOCKED_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && cfg_valid_i) |=> cfg_err_o); // R9

endmodule

bind icall_type_guard icg_checker u_icg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_i     (lock_i),
    .cfg_valid_i(cfg_valid_i),
    .pkt_valid_i(pkt_valid_i),
    .res_valid_o(res_valid_o),
    .res_pass_o (res_pass_o),
    .violation_o(violation_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/icall_type_guard_tb_top.sv
`timescale 1ns/1ps
module icall_type_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic        cfg_valid_i = 1'b0;
    logic [1:0]  cfg_sel_i = 2'b00;
    logic [7:0]  cfg_idx_i = 8'h0;
    logic [31:0] cfg_addr_i = 32'h0;
    logic [7:0]  cfg_type_i = 8'h0;
    logic        pkt_valid_i = 1'b0;
    logic [31:0] pkt_data_i = 32'h0;
    logic        res_valid_o, res_pass_o, violation_o, cfg_err_o;
    logic [7:0]  res_site_o;

    always #10 clk = ~clk;

    icall_type_guard dut_i (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i),
        .cfg_valid_i(cfg_valid_i), .cfg_sel_i(cfg_sel_i), .cfg_idx_i(cfg_idx_i),
        .cfg_addr_i(cfg_addr_i), .cfg_type_i(cfg_type_i),
        .pkt_valid_i(pkt_valid_i), .pkt_data_i(pkt_data_i),
        .res_valid_o(res_valid_o), .res_pass_o(res_pass_o), .res_site_o(res_site_o),
        .violation_o(violation_o), .cfg_err_o(cfg_err_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference model of the tables
    bit [7:0]  m_stype [256];
    bit        m_svld  [256];
    bit [31:0] m_foff  [256];
    bit [7:0]  m_ftype [256];
    bit        m_fvld  [256];
    bit [31:0] m_base = 32'h0;
    bit        exp_err = 1'b0;
    bit        exp_viol = 1'b0;

    // Scoreboard queues
    bit        q_pass [$];
    bit [7:0]  q_site [$];
    string     q_tag  [$];

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit model_pass(bit [7:0] site, bit [31:0] tgt);
        bit [31:0] key;
        if (!m_svld[site]) return 1'b0;
        key = tgt - m_base;
        for (int i = 0; i < 256; i++) begin
            if (m_fvld[i] && m_foff[i] == key) return (m_ftype[i] == m_stype[site]);
        end
        return 1'b0;
    endfunction

    task automatic cfg_write(bit [1:0] sel, bit [7:0] idx, bit [31:0] addr, bit [7:0] typ, string tag);
        @(negedge clk);
        cfg_valid_i = 1'b1; cfg_sel_i = sel; cfg_idx_i = idx;
        cfg_addr_i = addr; cfg_type_i = typ;
        if (lock_i) begin
            exp_err = 1'b1;
        end else begin
            case (sel)
                2'b00: m_base = addr;
                2'b01: begin m_stype[idx] = typ; m_svld[idx] = 1'b1; end
                2'b10: begin m_foff[idx] = addr; m_ftype[idx] = typ; m_fvld[idx] = 1'b1; end
                default: ;
            endcase
        end
        @(negedge clk);
        cfg_valid_i = 1'b0;
        chk(cfg_err_o == exp_err, tag, "cfg_err_o", cfg_err_o, exp_err);
    endtask

    task automatic push_exp(bit [7:0] site, bit [31:0] tgt, string tag);
        q_pass.push_back(model_pass(site, tgt));
        q_site.push_back(site);
        q_tag.push_back(tag);
    endtask

    task automatic send_call(bit [7:0] site, bit [31:0] tgt, string tag);
        push_exp(site, tgt, tag);
        @(negedge clk);
        pkt_valid_i = 1'b1; pkt_data_i = {24'h0, site};
        @(negedge clk);
        pkt_data_i = tgt;
        @(negedge clk);
        pkt_valid_i = 1'b0; pkt_data_i = 32'h0;
    endtask

    task automatic send_b2b(bit [7:0] s1, bit [31:0] t1, bit [7:0] s2, bit [31:0] t2, string tag);
        push_exp(s1, t1, tag);
        push_exp(s2, t2, tag);
        @(negedge clk); pkt_valid_i = 1'b1; pkt_data_i = {24'h0, s1};
        @(negedge clk); pkt_data_i = t1;
        @(negedge clk); pkt_data_i = {24'h0, s2};
        @(negedge clk); pkt_data_i = t2;
        @(negedge clk); pkt_valid_i = 1'b0; pkt_data_i = 32'h0;
    endtask

    // Monitor: pops expectations as verdicts appear
    always @(negedge clk) begin
        if (rst_n && res_valid_o) begin
            if (q_pass.size() == 0) begin
                chk(1'b0, "R2", "unexpected verdict", 32'h1, 32'h0);
            end else begin
                automatic bit    ep = q_pass.pop_front();
                automatic bit [7:0] es = q_site.pop_front();
                automatic string et = q_tag.pop_front();
                chk(res_pass_o == ep, et, "res_pass_o", res_pass_o, ep);
                chk(res_site_o == es, et, "res_site_o", res_site_o, es);
                if (!ep) exp_viol = 1'b1;
                chk(violation_o == exp_viol, "R7", "violation_o", violation_o, exp_viol);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(res_valid_o == 1'b0, "R1", "res_valid_o", res_valid_o, 0);
        chk(violation_o == 1'b0, "R1", "violation_o", violation_o, 0);
        chk(cfg_err_o == 1'b0, "R1", "cfg_err_o", cfg_err_o, 0);
        rst_n = 1'b1;
        send_call(8'd3, 32'h0000_0000, "R1"); // empty tables: must fail
        repeat (3) @(negedge clk);

        cfg_write(2'b00, 8'd0, 32'h1000_0000, 8'h00, "R9");
        cfg_write(2'b01, 8'd3, 32'h0, 8'h11, "R9");
        cfg_write(2'b01, 8'd7, 32'h0, 8'h22, "R9");
        cfg_write(2'b01, 8'd200, 32'h0, 8'h11, "R9");
        cfg_write(2'b10, 8'd0, 32'h0000_0100, 8'h11, "R9");
        cfg_write(2'b10, 8'd1, 32'h0000_0200, 8'h22, "R9");
        cfg_write(2'b10, 8'd5, 32'h0000_0340, 8'h11, "R9");
        cfg_write(2'b10, 8'd9, 32'h0000_0100, 8'h33, "R11");
        cfg_write(2'b11, 8'd3, 32'h0000_0100, 8'h22, "R3");

        send_call(8'd3, 32'h1000_0100, "R11");      // index 0 wins over index 9
        send_call(8'd200, 32'h1000_0340, "R3");
        send_call(8'd3, 32'h1000_0100, "R3");       // reserved write had no effect
        send_call(8'd7, 32'h1000_0100, "R4");       // type mismatch
        send_call(8'd7, 32'h1000_0200, "R7");       // pass keeps violation set
        send_call(8'd3, 32'h1000_0104, "R5");       // no function there
        send_call(8'd50, 32'h1000_0100, "R6");      // unknown site
        send_b2b(8'd3, 32'h1000_0200, 8'd7, 32'h1000_0200, "R10");
        send_b2b(8'd200, 32'h1000_0340, 8'd3, 32'h1000_0340, "R10");

        cfg_write(2'b00, 8'd0, 32'h2000_0000, 8'h00, "R8");
        send_call(8'd3, 32'h1000_0100, "R8");       // old location now unknown
        send_call(8'd3, 32'h2000_0100, "R8");

        @(negedge clk); lock_i = 1'b1;
        cfg_write(2'b01, 8'd3, 32'h0, 8'h22, "R9");
        send_call(8'd3, 32'h2000_0200, "R9");       // site entry unchanged: fail
        cfg_write(2'b00, 8'd0, 32'h3000_0000, 8'h00, "R9");
        send_call(8'd3, 32'h2000_0100, "R9");       // base unchanged: pass
        cfg_write(2'b10, 8'd2, 32'h0000_0500, 8'h11, "R9");
        send_call(8'd3, 32'h2000_0500, "R9");       // function not added: fail

        repeat (6) @(negedge clk);
        chk(q_pass.size() == 0, "R2", "pending verdicts", q_pass.size(), 0);
        finish_run();
    end

endmodule